// File: doc/BRIEF.md
# Rotating-Lane Burst Distribution Proxy

This block accepts memory beats of up to `LANES` elements and spreads them across `LANES` independent FIFOs, one per output lane. A write offset rotates by the number of elements in each accepted beat. Element `i` of a beat therefore lands in lane `(offset + i) mod LANES`, and the global element order is kept across lanes no matter how the beats are sized. A read offset rotates the same way on the consumer side. The compute pipe can take any number of elements from 1 to `LANES` in a cycle. It receives them packed toward lane 0 in arrival order, and every unused lane is driven to zero.

Row boundaries are handled by a two-state row controller. In `ROW_IDLE` it waits for a row descriptor with a nonzero length; that transition is `IDLE->STREAM`. In `ROW_STREAM` it tracks how many elements of the row are still owed. Each delivered beat is capped at that remainder, so the final beat of a row carries only the leftover elements and raises `out_last`. On that same final beat the controller accepts the next descriptor and stays in `ROW_STREAM` (the `STREAM->STREAM` reload). Without a waiting descriptor it returns to `ROW_IDLE` (`STREAM->IDLE`). A descriptor of length zero is accepted in `ROW_IDLE` and leaves the state unchanged (`IDLE->IDLE`). Pushes and pulls may happen in the same cycle.

Top module: `burst_lane_proxy`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1 and `row_ready` is 1.
- R2: `in_cnt` gives the number of valid elements in a beat, placed in lanes 0 to n-1 of `in_data`. A code of 0, or any value above `LANES`, means `LANES`. Lanes of `in_data` at or beyond n are ignored. Element i goes to lane FIFO (o+i) mod `LANES`, after which o advances by n mod `LANES`.
- R3: `in_ready` is low exactly when at least one lane FIFO targeted by the beat is full. A refused beat changes nothing and is taken once it is accepted.
- R4: A delivered beat carries `out_cnt` = min(m, remaining row count) elements, where m is `pull_m` and a code of 0 or above `LANES` means `LANES`.
- R5: Lanes of `out_data` at index `out_cnt` and above are zero whenever `out_valid` is high.
- R6: `out_valid` is high only when a row is active, `pull_req` is high and every element of the granted count is present. Otherwise it is low and nothing is consumed.
- R7: `out_last` marks the beat that exhausts the row. `row_ready` is high in that cycle, and a descriptor accepted then starts delivering on the next cycle.
- R8: A row descriptor of length 0 is accepted and produces no output beat.
- R9: A push and a pull in the same cycle both take effect, including when they touch the same lane FIFO.
- R10: Across all beats and rows, elements leave in exactly the order they arrived, with none lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Memory beat present |
| in_ready | output | 1 | Beat accepted this cycle |
| in_cnt | input | GW | Valid elements in the beat (0 means LANES) |
| in_data | input | LANES*DATA_W | Beat elements, element 0 in the low lane |
| row_valid | input | 1 | Row descriptor present |
| row_ready | output | 1 | Row descriptor accepted this cycle |
| row_len | input | LEN_W | Element count of the row |
| pull_req | input | 1 | Consumer wants a beat |
| pull_m | input | GW | Requested element count (0 means LANES) |
| out_valid | output | 1 | Beat delivered this cycle |
| out_cnt | output | GW | Elements in the delivered beat |
| out_last | output | 1 | Beat ends the row |
| out_data | output | LANES*DATA_W | Packed elements, zero-filled above out_cnt |

## Verification
A corrupted write or read offset shows up on the first beat after the fault as elements out of arrival order or in the wrong lanes. The scoreboard, which compares every element against the order the elements were pushed, catches this immediately. A wrong remaining count shows up on the same beat as a wrong `out_cnt` or a misplaced `out_last`. The bench predicts `out_valid` every cycle from the occupancy it tracks, so a lane count that drifts makes `out_valid` or `in_ready` disagree within one cycle.

// File: rtl/blp_pkg.sv
package blp_pkg;
    typedef enum logic [0:0] {
        ROW_IDLE   = 1'b0,
        ROW_STREAM = 1'b1
    } row_state_e;
endpackage

// File: rtl/blp_lane_fifo.sv
module blp_lane_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [DATA_W-1:0]            wdata,
    input  logic                         pop,
    output logic [DATA_W-1:0]            rdata,
    output logic [$clog2(DEPTH):0]       count
);
    localparam int AW = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW:0]       wr_ptr;
    logic [AW:0]       rd_ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr[AW-1:0]] <= wdata;
    end

    assign rdata = mem[rd_ptr[AW-1:0]];
    assign count = wr_ptr - rd_ptr;
endmodule

// File: rtl/blp_write_router.sv
module blp_write_router #(
    parameter int LANES  = 4,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   in_valid,
    input  logic [$clog2(LANES+1)-1:0]             in_cnt,
    input  logic [LANES*DATA_W-1:0]                in_data,
    input  logic [LANES*($clog2(DEPTH)+1)-1:0]     lane_count,
    output logic                                   in_ready,
    output logic [LANES-1:0]                       lane_push,
    output logic [LANES*DATA_W-1:0]                lane_wdata
);
    localparam int GW = $clog2(LANES+1);
    localparam int CW = $clog2(DEPTH) + 1;
    localparam int OW = $clog2(LANES);
    localparam int SW = $clog2(2*LANES) + 1;

    logic [SW-1:0]     wr_off;
    logic [SW-1:0]     n_eff;
    logic [SW-1:0]     sum_raw;
    logic [SW-1:0]     sum_wrap;
    logic [LANES-1:0]  tgt;
    logic [LANES-1:0]  room;
    logic              accept;
    logic [DATA_W-1:0] in_el [LANES];

    assign n_eff = (in_cnt == '0 || in_cnt > GW'(LANES)) ? SW'(LANES) : SW'(in_cnt);

    for (genvar e = 0; e < LANES; e++) begin : g_unpack
        assign in_el[e] = in_data[e*DATA_W +: DATA_W];
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [SW-1:0] raw;
        logic [SW-1:0] idx;
        assign raw     = SW'(l + LANES) - wr_off;
        assign idx     = (raw >= SW'(LANES)) ? raw - SW'(LANES) : raw;
        assign tgt[l]  = idx < n_eff;
        assign room[l] = lane_count[l*CW +: CW] != CW'(DEPTH);
        assign lane_wdata[l*DATA_W +: DATA_W] = in_el[idx[OW-1:0]];
        assign lane_push[l] = accept & tgt[l];
    end

    assign in_ready = &(~tgt | room);
    assign accept   = in_valid & in_ready;
    assign sum_raw  = wr_off + n_eff;
    assign sum_wrap = (sum_raw >= SW'(LANES)) ? sum_raw - SW'(LANES) : sum_raw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      wr_off <= '0;
        else if (accept) wr_off <= sum_wrap;
    end
endmodule

// File: rtl/blp_read_gather.sv
module blp_read_gather #(
    parameter int LANES  = 4,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   active,
    input  logic                                   pull_req,
    input  logic [$clog2(LANES+1)-1:0]             grant,
    input  logic [LANES*DATA_W-1:0]                lane_rdata,
    input  logic [LANES*($clog2(DEPTH)+1)-1:0]     lane_count,
    output logic                                   out_valid,
    output logic [LANES*DATA_W-1:0]                out_data,
    output logic [LANES-1:0]                       lane_pop
);
    localparam int GW = $clog2(LANES+1);
    localparam int CW = $clog2(DEPTH) + 1;
    localparam int OW = $clog2(LANES);
    localparam int SW = $clog2(2*LANES) + 1;

    logic [SW-1:0]     rd_off;
    logic [SW-1:0]     sum_raw;
    logic [SW-1:0]     sum_wrap;
    logic [LANES-1:0]  slot_ok;
    logic [LANES-1:0]  lane_has;
    logic [DATA_W-1:0] lane_el [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_view
        assign lane_el[l]  = lane_rdata[l*DATA_W +: DATA_W];
        assign lane_has[l] = lane_count[l*CW +: CW] != '0;
    end

    for (genvar j = 0; j < LANES; j++) begin : g_slot
        logic [SW-1:0] raw;
        logic [SW-1:0] src;
        logic          used;
        assign raw        = SW'(j) + rd_off;
        assign src        = (raw >= SW'(LANES)) ? raw - SW'(LANES) : raw;
        assign used       = GW'(j) < grant;
        assign slot_ok[j] = ~used | lane_has[src[OW-1:0]];
        assign out_data[j*DATA_W +: DATA_W] = used ? lane_el[src[OW-1:0]] : '0;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_pop
        logic [SW-1:0] raw;
        logic [SW-1:0] idx;
        assign raw         = SW'(l + LANES) - rd_off;
        assign idx         = (raw >= SW'(LANES)) ? raw - SW'(LANES) : raw;
        assign lane_pop[l] = out_valid & (idx < SW'(grant));
    end

    assign out_valid = active & pull_req & (grant != '0) & (&slot_ok);
    assign sum_raw   = rd_off + SW'(grant);
    assign sum_wrap  = (sum_raw >= SW'(LANES)) ? sum_raw - SW'(LANES) : sum_raw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         rd_off <= '0;
        else if (out_valid) rd_off <= sum_wrap;
    end
endmodule

// File: rtl/blp_row_ctrl.sv
module blp_row_ctrl
    import blp_pkg::*;
#(
    parameter int LANES = 4,
    parameter int LEN_W = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        row_valid,
    input  logic [LEN_W-1:0]            row_len,
    output logic                        row_ready,
    input  logic [$clog2(LANES+1)-1:0]  pull_m,
    input  logic                        fire,
    output logic                        active,
    output logic [$clog2(LANES+1)-1:0]  grant,
    output logic                        last
);
    localparam int GW = $clog2(LANES+1);

    row_state_e       state, state_nx;
    logic [LEN_W-1:0] remain, remain_nx;
    logic [GW-1:0]    m_eff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ROW_IDLE;
            remain <= '0;
        end else begin
            state  <= state_nx;
            remain <= remain_nx;
        end
    end

    always_comb begin
        m_eff     = (pull_m == '0 || pull_m > GW'(LANES)) ? GW'(LANES) : pull_m;
        grant     = (remain < LEN_W'(m_eff)) ? GW'(remain) : m_eff;
        active    = (state == ROW_STREAM);
        last      = active && (remain <= LEN_W'(m_eff));
        state_nx  = state;
        remain_nx = remain;
        row_ready = 1'b0;
        unique case (state)
            ROW_IDLE: begin
                row_ready = 1'b1;
                if (row_valid && row_len != '0) begin
                    state_nx  = ROW_STREAM;
                    remain_nx = row_len;
                end
            end
            ROW_STREAM: begin
                if (fire) begin
                    if (last) begin
                        row_ready = 1'b1;
                        if (row_valid && row_len != '0) begin
                            remain_nx = row_len;
                        end else begin
                            state_nx  = ROW_IDLE;
                            remain_nx = '0;
                        end
                    end else begin
                        remain_nx = remain - LEN_W'(grant);
                    end
                end
            end
            default: begin
                state_nx  = ROW_IDLE;
                remain_nx = '0;
            end
        endcase
    end
endmodule

// File: rtl/burst_lane_proxy.sv
module burst_lane_proxy #(
    parameter int LANES  = 4,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4,
    parameter int LEN_W  = 12
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               in_valid,
    output logic                               in_ready,
    input  logic [$clog2(LANES+1)-1:0]         in_cnt,
    input  logic [LANES*DATA_W-1:0]            in_data,
    input  logic                               row_valid,
    output logic                               row_ready,
    input  logic [LEN_W-1:0]                   row_len,
    input  logic                               pull_req,
    input  logic [$clog2(LANES+1)-1:0]         pull_m,
    output logic                               out_valid,
    output logic [$clog2(LANES+1)-1:0]         out_cnt,
    output logic                               out_last,
    output logic [LANES*DATA_W-1:0]            out_data
);
    localparam int GW = $clog2(LANES+1);
    localparam int CW = $clog2(DEPTH) + 1;

    logic [LANES-1:0]          lane_push;
    logic [LANES-1:0]          lane_pop;
    logic [LANES*DATA_W-1:0]   lane_wdata;
    logic [LANES*DATA_W-1:0]   lane_rdata;
    logic [LANES*CW-1:0]       lane_count_flat;
    logic                      active;
    logic                      last;
    logic [GW-1:0]             grant;

    for (genvar l = 0; l < LANES; l++) begin : g_fifo
        blp_lane_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (lane_push[l]),
            .wdata (lane_wdata[l*DATA_W +: DATA_W]),
            .pop   (lane_pop[l]),
            .rdata (lane_rdata[l*DATA_W +: DATA_W]),
            .count (lane_count_flat[l*CW +: CW])
        );
    end

    blp_write_router #(.LANES(LANES), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_cnt     (in_cnt),
        .in_data    (in_data),
        .lane_count (lane_count_flat),
        .in_ready   (in_ready),
        .lane_push  (lane_push),
        .lane_wdata (lane_wdata)
    );

    blp_row_ctrl #(.LANES(LANES), .LEN_W(LEN_W)) u_row (
        .clk       (clk),
        .rst_n     (rst_n),
        .row_valid (row_valid),
        .row_len   (row_len),
        .row_ready (row_ready),
        .pull_m    (pull_m),
        .fire      (out_valid),
        .active    (active),
        .grant     (grant),
        .last      (last)
    );

    blp_read_gather #(.LANES(LANES), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .pull_req   (pull_req),
        .grant      (grant),
        .lane_rdata (lane_rdata),
        .lane_count (lane_count_flat),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .lane_pop   (lane_pop)
    );

    assign out_cnt  = out_valid ? grant : '0;
    assign out_last = out_valid & last;
endmodule

// File: rtl/blp_checker.sv
module blp_checker #(
    parameter int LANES  = 4,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               pull_req,
    input logic [$clog2(LANES+1)-1:0]         pull_m,
    input logic                               out_valid,
    input logic [$clog2(LANES+1)-1:0]         out_cnt,
    input logic                               out_last,
    input logic [LANES*DATA_W-1:0]            out_data,
    input logic                               row_ready,
    input logic [LANES*($clog2(DEPTH)+1)-1:0] lane_count
);
    localparam int GW = $clog2(LANES+1);
    localparam int CW = $clog2(DEPTH) + 1;

    for (genvar l = 0; l < LANES; l++) begin : g_occ
        // R3: no lane FIFO is ever written beyond its depth
        p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
            lane_count[l*CW +: CW] <= CW'(DEPTH));
    end

    for (genvar j = 0; j < LANES; j++) begin : g_pad
        // R5: lanes above the delivered count are zero
        p_pad_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && out_cnt <= GW'(j)) |-> out_data[j*DATA_W +: DATA_W] == '0);
    end

    // R4: a delivered beat carries between one and LANES elements
    p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_cnt != '0 && out_cnt <= GW'(LANES)));

    // R4: a full-width request that does not end a row is served in full
    p_full_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last && (pull_m == '0 || pull_m >= GW'(LANES)))
            |-> out_cnt == GW'(LANES));

    // R6: no beat without a consumer request
    p_req_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> pull_req);

    // R7: the row-ending beat opens the descriptor port
    p_next_row_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> row_ready);
endmodule

bind burst_lane_proxy blp_checker #(.LANES(LANES), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pull_req   (pull_req),
    .pull_m     (pull_m),
    .out_valid  (out_valid),
    .out_cnt    (out_cnt),
    .out_last   (out_last),
    .out_data   (out_data),
    .row_ready  (row_ready),
    .lane_count (lane_count_flat)
);

// File: tb/burst_lane_proxy_test.sv
`timescale 1ns/1ps
module burst_lane_proxy_test;
    localparam int K     = 4;
    localparam int DW    = 16;
    localparam int DEPTH = 4;
    localparam int LW    = 12;
    localparam int GW    = $clog2(K+1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [GW-1:0]     in_cnt = '0;
    logic [K*DW-1:0]   in_data = '0;
    logic              row_valid = 1'b0;
    logic              row_ready;
    logic [LW-1:0]     row_len = '0;
    logic              pull_req = 1'b0;
    logic [GW-1:0]     pull_m = GW'(K);
    logic              out_valid;
    logic [GW-1:0]     out_cnt;
    logic              out_last;
    logic [K*DW-1:0]   out_data;

    int          n_checks = 0;
    int          n_fail   = 0;
    bit          finished = 1'b0;
    int          saw_both = 0;
    logic [DW-1:0] exp_q[$];
    int          rows_q[$];
    int          cur_rem = 0;
    logic [DW-1:0] seq = 16'h0100;

    always #4 clk = ~clk;

    burst_lane_proxy #(.LANES(K), .DATA_W(DW), .DEPTH(DEPTH), .LEN_W(LW)) uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_cnt(in_cnt), .in_data(in_data),
        .row_valid(row_valid), .row_ready(row_ready), .row_len(row_len),
        .pull_req(pull_req), .pull_m(pull_m),
        .out_valid(out_valid), .out_cnt(out_cnt), .out_last(out_last), .out_data(out_data)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Scoreboard monitor: compares each delivered beat, then records accepted inputs
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int  m_eff;
            int  g;
            int  sz0;
            int  n_in;
            bit  exp_v;
            sz0 = exp_q.size();
            while (cur_rem == 0 && rows_q.size() > 0) cur_rem = rows_q.pop_front();
            m_eff = (pull_m == 0 || pull_m > K) ? K : int'(pull_m);
            g     = (cur_rem < m_eff) ? cur_rem : m_eff;
            exp_v = pull_req && g > 0 && sz0 >= g;
            check(out_valid == exp_v, "R6", "out_valid", out_valid, exp_v);
            if (out_valid && exp_v) begin
                check(out_cnt == g, "R4", "out_cnt", out_cnt, g);
                check(out_last == (g == cur_rem), "R7", "out_last", out_last, g == cur_rem);
                if (out_last) check(row_ready == 1'b1, "R7", "row_ready at row end", row_ready, 1);
                for (int j = 0; j < K; j++) begin
                    if (j < g)
                        check(out_data[j*DW +: DW] == exp_q[j], "R2 R10", "lane data",
                              out_data[j*DW +: DW], exp_q[j]);
                    else
                        check(out_data[j*DW +: DW] == '0, "R5", "pad lane",
                              out_data[j*DW +: DW], 0);
                end
                for (int j = 0; j < g; j++) void'(exp_q.pop_front());
                cur_rem -= g;
            end
            n_in = (in_cnt == 0 || in_cnt > K) ? K : int'(in_cnt);
            if (in_valid && n_in == K)
                check(in_ready == (sz0 <= (DEPTH-1)*K), "R3", "in_ready vs occupancy",
                      in_ready, sz0 <= (DEPTH-1)*K);
            if (in_valid && in_ready) begin
                if (out_valid) saw_both++;
                for (int i = 0; i < n_in; i++) exp_q.push_back(in_data[i*DW +: DW]);
            end
            if (row_valid && row_ready) rows_q.push_back(int'(row_len));
        end
    end

    task automatic push_beat(input int code);
        int ne;
        ne = (code == 0) ? K : code;
        in_valid = 1'b1;
        in_cnt   = GW'(code);
        for (int i = 0; i < K; i++)
            in_data[i*DW +: DW] = (i < ne) ? seq + DW'(i) : 16'hEEEE;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0;
        seq = seq + DW'(ne);
    endtask

    task automatic give_row(input int len);
        row_valid = 1'b1;
        row_len   = LW'(len);
        do @(negedge clk); while (!row_ready);
        @(posedge clk); #1;
        row_valid = 1'b0;
    endtask

    task automatic wait_rows_done();
        do begin @(negedge clk); #1; end while (cur_rem != 0 || rows_q.size() != 0);
        @(posedge clk); #1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL R6 watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int ms[5] = '{3, 1, 2, 0, 7};
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        check(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
        check(row_ready == 1'b1, "R1", "row_ready in reset", row_ready, 1);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // R6: no row, no data
        pull_req = 1'b1;
        pull_m   = GW'(4);
        repeat (3) @(posedge clk);
        #1;
        give_row(6);
        push_beat(3);
        @(negedge clk);
        check(out_valid == 1'b0, "R6", "partial data below grant", out_valid, 0);
        @(posedge clk); #1;
        push_beat(0);
        wait_rows_done();

        // R2 R4 R7 R8: mixed beat sizes, row lengths and request widths
        fork
            begin
                push_beat(1); push_beat(4); push_beat(2); push_beat(3); push_beat(4);
                push_beat(4); push_beat(0); push_beat(1); push_beat(3);
            end
            begin
                give_row(5); give_row(0); give_row(3); give_row(9); give_row(1);
            end
            begin
                foreach (ms[i]) begin
                    pull_m = GW'(ms[i]);
                    repeat (8) @(posedge clk);
                    #1;
                end
            end
        join
        wait_rows_done();

        // R8: zero-length row with data waiting
        give_row(0);
        @(negedge clk);
        check(out_valid == 1'b0, "R8", "beat from empty row", out_valid, 0);
        check(row_ready == 1'b1, "R8", "row_ready after empty row", row_ready, 1);
        @(posedge clk); #1;

        // R3 then R9: fill to back-pressure, then push and pull together
        pull_req = 1'b0;
        fork
            begin
                push_beat(4); push_beat(4); push_beat(4); push_beat(4);
            end
            begin
                repeat (6) @(posedge clk);
                @(negedge clk);
                check(in_ready == 1'b0, "R3", "in_ready with full lanes", in_ready, 0);
                @(posedge clk); #1;
                pull_m   = GW'(2);
                pull_req = 1'b1;
                give_row(20);
            end
        join
        wait_rows_done();
        check(saw_both > 0, "R9", "cycles with push and pull", saw_both, 1);

        // R4: request codes above LANES and zero both mean LANES
        pull_m = GW'(7);
        give_row(5);
        wait_rows_done();
        pull_m = GW'(0);
        fork
            give_row(7);
            begin push_beat(2); push_beat(4); push_beat(1); end
        join
        wait_rows_done();

        repeat (4) @(posedge clk);
        check(exp_q.size() == 0, "R10", "elements left undelivered", exp_q.size(), 0);
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule